// File: doc/BRIEF.md
# Floating-Point Register List Transfer Sequencer

This block moves a chosen group of wide floating-point registers between a register file and memory, one 32-bit word at a time. Each register is treated as a raw 96-bit value and occupies three consecutive memory words (12 bytes). No format conversion takes place. An 8-bit list selects the registers. The list comes either from an immediate field or from the low byte of one of four data registers, and a 2-bit list mode picks the list source and the direction of traversal.

A transfer starts with a one-cycle `start` pulse while the block is idle. The block then issues memory requests and waits for an acknowledge on each one. On a store it reads registers through a combinational register-file read port. On a load it writes each register back once its three words have been collected. At the end it raises a one-cycle `done` pulse and presents the final address. It also reports whether that address must be written back to the address register, which is the case only for the post-increment and pre-decrement addressing kinds.

Top module: `fpreg_burst_mover`

## Requirements
- R1: After reset, `busy`, `mem_req`, `rf_we` and `done` are all low.
- R2: `list_mode` encoding: 0 = immediate list, descending; 1 = data-register list, descending; 2 = immediate list, ascending; 3 = data-register list, ascending. In data-register modes the list is `dreg_lows[8*dreg_sel +: 8]`. Otherwise it is `imm_list`.
- R3: In ascending modes, list bit 7-i selects register i. In descending modes, list bit i selects register i. Selected registers are served in increasing register index, and unselected registers are never written.
- R4: In an ascending store, each register's words go to addresses A, A+4 and A+8 in the order word1 (bits 95:64), word2 (bits 63:32), word3 (bits 31:0). A starts at `base_addr` and ends at `base_addr + 12*n`, where n is the number of selected registers.
- R5: In a descending store, each word is written after a 4-byte decrement, in the order word3, word2, word1. The final address is `base_addr - 12*n`.
- R6: A load reads the same addresses in the same order as a store of the same list and mode. It writes the assembled 96-bit value to register `rf_idx` with a one-cycle `rf_we` pulse in the cycle after the acknowledge of that register's last word.
- R7: Exactly one word moves for each cycle in which `mem_req` and `mem_ack` are both high. While a request waits for its acknowledge, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R8: An empty list causes no memory request and no register write. `done` rises in the cycle after `start`, and `final_addr` equals `base_addr`.
- R9: `done` is a one-cycle pulse after the last transfer. With it, `final_wb` is 1 when `ea_kind` is 1 (post-increment) or 2 (pre-decrement), and 0 for any other value.
- R10: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| list_mode | input | 2 | List source and traversal direction |
| imm_list | input | 8 | Immediate register list |
| dreg_sel | input | 2 | Data register supplying the list in dynamic modes |
| dreg_lows | input | 32 | Low bytes of the four data registers |
| ea_kind | input | 2 | Addressing kind: 0 control, 1 post-increment, 2 pre-decrement |
| base_addr | input | 32 | Starting address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address (byte units) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory acknowledge |
| rf_idx | output | 3 | Register file index for read and write |
| rf_rdata | input | 96 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 96 | Register file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| final_addr | output | 32 | Address after the transfer |
| final_wb | output | 1 | Final address is to be written back (valid with `done`) |

## Verification
The bench builds the block with its default parameters: eight registers, three 32-bit words per register, and four data registers providing 8-bit lists. With these values every one of the 256 list patterns is reachable in both directions and from every list source, including the empty and full lists and single-register lists at either end of the mask. Acknowledges are withheld at random, so the hold behaviour of a waiting request and transfers of up to 24 words with stalls fall within the run.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_RFWR = 2'd2,
        ST_DONE = 2'd3
    } fpmv_state_e;

    // Addressing kinds that request an address write-back
    localparam logic [1:0] EA_POSTINC = 2'd1;
    localparam logic [1:0] EA_PREDEC  = 2'd2;

endpackage

// File: rtl/fpmv_mask_prep.sv
module fpmv_mask_prep #(
    parameter int NREG  = 8,
    parameter int NDREG = 4
) (
    input  logic [1:0]               list_mode,
    input  logic [NREG-1:0]          imm_list,
    input  logic [$clog2(NDREG)-1:0] dreg_sel,
    input  logic [NDREG*NREG-1:0]    dreg_lows,
    output logic [NREG-1:0]          reg_mask,
    output logic                     descending
);
    logic [NREG-1:0] raw_list;

    // bit 0 of the mode picks the data-register list, bit 1 picks ascending order
    assign raw_list   = list_mode[0] ? dreg_lows[dreg_sel*NREG +: NREG] : imm_list;
    assign descending = ~list_mode[1];

    // bit i of reg_mask always stands for register i
    for (genvar g = 0; g < NREG; g++) begin : g_map
        assign reg_mask[g] = descending ? raw_list[g] : raw_list[NREG-1-g];
    end
endmodule

// File: rtl/fpmv_pick.sv
module fpmv_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         vec,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // lowest set bit wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/fpmv_word_lane.sv
module fpmv_word_lane #(
    parameter int WORD_W = 32,
    parameter int WPR    = 3
) (
    input  logic [$clog2(WPR)-1:0]  slot,
    input  logic [WORD_W*WPR-1:0]   reg_in,
    output logic [WORD_W-1:0]       word_out,
    input  logic [WORD_W*WPR-1:0]   acc_in,
    input  logic [WORD_W-1:0]       word_in,
    output logic [WORD_W*WPR-1:0]   acc_out
);
    localparam int SLW = $clog2(WPR);

    // slot 0 is the most significant word of the register
    always_comb begin
        word_out = '0;
        for (int k = 0; k < WPR; k++) begin
            if (slot == SLW'(k)) word_out = reg_in[(WPR-1-k)*WORD_W +: WORD_W];
        end
    end

    for (genvar g = 0; g < WPR; g++) begin : g_slot
        assign acc_out[(WPR-1-g)*WORD_W +: WORD_W] =
            (slot == SLW'(g)) ? word_in : acc_in[(WPR-1-g)*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/fpreg_burst_mover.sv
module fpreg_burst_mover
    import fpmv_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int WORD_W = 32,
    parameter int WPR    = 3,
    parameter int ADDR_W = 32,
    parameter int NDREG  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      store,
    input  logic [1:0]                list_mode,
    input  logic [NREG-1:0]           imm_list,
    input  logic [$clog2(NDREG)-1:0]  dreg_sel,
    input  logic [NDREG*NREG-1:0]     dreg_lows,
    input  logic [1:0]                ea_kind,
    input  logic [ADDR_W-1:0]         base_addr,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    input  logic [WORD_W-1:0]         mem_rdata,
    input  logic                      mem_ack,
    output logic [$clog2(NREG)-1:0]   rf_idx,
    input  logic [WORD_W*WPR-1:0]     rf_rdata,
    output logic                      rf_we,
    output logic [WORD_W*WPR-1:0]     rf_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [ADDR_W-1:0]         final_addr,
    output logic                      final_wb
);
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = $clog2(WPR);
    localparam int REG_W = WORD_W * WPR;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
    localparam logic [CNT_W-1:0]  LAST = CNT_W'(WPR - 1);

    typedef struct packed {
        fpmv_state_e        st;
        logic               store;
        logic               down;
        logic               wb;
        logic [NREG-1:0]    pend;
        logic [CNT_W-1:0]   wcnt;
        logic [ADDR_W-1:0]  addr;
        logic [REG_W-1:0]   acc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NREG-1:0]  prep_mask;
    logic             prep_down;
    logic             cur_any;
    logic [IDX_W-1:0] cur_idx;
    logic [NREG-1:0]  cur_bit;
    logic [NREG-1:0]  remain;
    logic [CNT_W-1:0] slot;
    logic [REG_W-1:0] lane_acc;
    logic [ADDR_W-1:0] step_addr;
    logic             last_word;

    fpmv_mask_prep #(.NREG(NREG), .NDREG(NDREG)) u_prep (
        .list_mode  (list_mode),
        .imm_list   (imm_list),
        .dreg_sel   (dreg_sel),
        .dreg_lows  (dreg_lows),
        .reg_mask   (prep_mask),
        .descending (prep_down)
    );

    fpmv_pick #(.N(NREG)) u_pick (
        .vec (ctl_q.pend),
        .any (cur_any),
        .idx (cur_idx)
    );

    fpmv_word_lane #(.WORD_W(WORD_W), .WPR(WPR)) u_lane (
        .slot     (slot),
        .reg_in   (rf_rdata),
        .word_out (mem_wdata),
        .acc_in   (ctl_q.acc),
        .word_in  (mem_rdata),
        .acc_out  (lane_acc)
    );

    assign cur_bit   = cur_any ? ({{(NREG-1){1'b0}}, 1'b1} << cur_idx) : '0;
    assign remain    = ctl_q.pend & ~cur_bit;
    // descending traversal visits the words last-to-first
    assign slot      = ctl_q.down ? (LAST - ctl_q.wcnt) : ctl_q.wcnt;
    assign step_addr = ctl_q.down ? (ctl_q.addr - STEP) : (ctl_q.addr + STEP);
    assign last_word = (ctl_q.wcnt == LAST);

    assign mem_addr   = ctl_q.down ? (ctl_q.addr - STEP) : ctl_q.addr;
    assign rf_idx     = cur_idx;
    assign rf_wdata   = ctl_q.acc;
    assign busy       = (ctl_q.st != ST_IDLE);
    assign final_addr = ctl_q.addr;
    assign final_wb   = done & ctl_q.wb;

    always_comb begin
        ctl_d   = ctl_q;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        rf_we   = 1'b0;
        done    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.store = store;
                    ctl_d.down  = prep_down;
                    ctl_d.wb    = (ea_kind == EA_POSTINC) || (ea_kind == EA_PREDEC);
                    ctl_d.pend  = prep_mask;
                    ctl_d.addr  = base_addr;
                    ctl_d.wcnt  = '0;
                    ctl_d.acc   = '0;
                    ctl_d.st    = (|prep_mask) ? ST_MOVE : ST_DONE;
                end
            end
            ST_MOVE: begin
                mem_req = 1'b1;
                mem_we  = ctl_q.store;
                if (mem_ack) begin
                    ctl_d.addr = step_addr;
                    ctl_d.acc  = lane_acc;
                    if (last_word) begin
                        ctl_d.wcnt = '0;
                        if (ctl_q.store) begin
                            ctl_d.pend = remain;
                            ctl_d.st   = (|remain) ? ST_MOVE : ST_DONE;
                        end else begin
                            ctl_d.st = ST_RFWR;
                        end
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + CNT_W'(1);
                    end
                end
            end
            ST_RFWR: begin
                rf_we      = 1'b1;
                ctl_d.pend = remain;
                ctl_d.st   = (|remain) ? ST_MOVE : ST_DONE;
            end
            ST_DONE: begin
                done     = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    empty_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (prep_mask == '0)) |=> (done && !mem_req && !rf_we));

    // R6
    rf_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_req && mem_ack && !mem_we));

    // R4 R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (final_addr == ($past(ctl_q.down) ? $past(mem_addr) : ($past(mem_addr) + STEP))));

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);
endmodule

// File: tb/sim_fpreg_burst_mover.sv
module sim_fpreg_burst_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, store = 1'b0;
    logic [1:0]  list_mode = '0, dreg_sel = '0, ea_kind = '0;
    logic [7:0]  imm_list = '0;
    logic [31:0] dreg_lows = '0, base_addr = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  rf_idx;
    logic [95:0] rf_rdata, rf_wdata;
    logic        rf_we, busy, done, final_wb;
    logic [31:0] final_addr;

    logic [95:0] rf [8];
    logic [31:0] mem [256];

    int total = 0, bad = 0, cyc = 0;
    int log_n = 0, req_cyc = 0, rfw_n = 0, done_seen = 0;
    logic [31:0] log_addr [32];
    logic [31:0] log_data [32];
    logic        log_we [32];
    logic [31:0] cap_final;
    logic        cap_wb;
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr, prev_wdata;

    always #2 clk = ~clk;

    assign rf_rdata  = rf[rf_idx];
    assign mem_rdata = mem[mem_addr[9:2]];

    fpreg_burst_mover u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .store(store), .list_mode(list_mode),
        .imm_list(imm_list), .dreg_sel(dreg_sel), .dreg_lows(dreg_lows), .ea_kind(ea_kind),
        .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rf_idx(rf_idx),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata), .busy(busy), .done(done),
        .final_addr(final_addr), .final_wb(final_wb)
    );

    task automatic chk(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory and register file models, sampled at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) begin
            // R7 request hold while unacknowledged
            if (prev_wait && mem_req)
                chk(mem_addr == prev_addr && (!mem_we || mem_wdata == prev_wdata),
                    "R7 hold", {mem_addr, mem_wdata}, {prev_addr, prev_wdata});
            if (mem_req) req_cyc++;
            mem_ack = mem_req && (($urandom % 4) != 0);
            prev_wait  = mem_req && !mem_ack;
            prev_addr  = mem_addr;
            prev_wdata = mem_wdata;
            if (mem_ack && log_n < 32) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
                log_we[log_n]   = mem_we;
                log_n++;
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            end
            if (rf_we) begin
                rf[rf_idx] = rf_wdata;
                rfw_n++;
            end
            if (done) begin
                done_seen++;
                cap_final = final_addr;
                cap_wb    = final_wb;
            end
        end
    end

    task automatic run_op(input logic st, input logic [1:0] md, input logic [7:0] imm,
                          input logic [1:0] ds, input logic [31:0] dl, input logic [1:0] ea,
                          input logic [31:0] base, input logic inject);
        logic [7:0]  lst;
        logic        dn;
        logic [31:0] a;
        int          n, t, nsel;
        logic [95:0] exp_rf [8];
        logic [31:0] e_addr [24];
        logic [31:0] e_data [24];
        lst = md[0] ? dl[8*ds +: 8] : imm;
        dn  = !md[1];
        n = 0; nsel = 0; a = base;
        for (int r = 0; r < 8; r++) begin
            exp_rf[r] = rf[r];
            if (dn ? lst[r] : lst[7-r]) begin
                nsel++;
                for (int k = 0; k < 3; k++) begin
                    int w;
                    if (dn) begin a = a - 4; w = 3 - k; end
                    else w = k + 1;
                    e_addr[n] = a;
                    e_data[n] = st ? rf[r][(3-w)*32 +: 32] : mem[a[9:2]];
                    exp_rf[r][(3-w)*32 +: 32] = e_data[n];
                    if (!dn) a = a + 4;
                    n++;
                end
            end
        end
        @(negedge clk); #1;
        log_n = 0; req_cyc = 0; rfw_n = 0; done_seen = 0;
        store = st; list_mode = md; imm_list = imm; dreg_sel = ds; dreg_lows = dl;
        ea_kind = ea; base_addr = base; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (inject) begin
            @(negedge clk); #1;
            store = ~st; imm_list = ~imm; list_mode = md ^ 2'b10; base_addr = base + 32'h40;
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        t = 0;
        while (done_seen == 0 && t < 400) begin
            @(negedge clk); #1;
            t++;
        end
        chk(done_seen == 1, "R9 done seen", 96'(done_seen), 96'd1);
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done pulse width", 96'(done), 96'd0);
        repeat (4) @(negedge clk);
        #1;
        chk(log_n == n, inject ? "R10 transfer count" : "R3 transfer count", 96'(log_n), 96'(n));
        if (nsel == 0) begin
            chk(req_cyc == 0 && rfw_n == 0, "R8 no activity", 96'(req_cyc + rfw_n), 96'd0);
            chk(cap_final == base, "R8 final addr", 96'(cap_final), 96'(base));
        end
        for (int i = 0; i < n && i < log_n; i++) begin
            chk(log_addr[i] == e_addr[i] && log_we[i] == st,
                dn ? "R5 word address" : "R4 word address", {log_we[i], log_addr[i]}, {st, e_addr[i]});
            chk(log_data[i] == e_data[i], st ? (dn ? "R5 word data" : "R4 word data") : "R6 read data",
                96'(log_data[i]), 96'(e_data[i]));
        end
        chk(cap_final == a, dn ? "R5 final addr" : "R4 final addr", 96'(cap_final), 96'(a));
        chk(cap_wb == (ea == 2'd1 || ea == 2'd2), "R9 final_wb", 96'(cap_wb), 96'(ea == 2'd1 || ea == 2'd2));
        if (!st) begin
            chk(rfw_n == nsel, "R6 rf write count", 96'(rfw_n), 96'(nsel));
            for (int r = 0; r < 8; r++)
                chk(rf[r] == exp_rf[r], "R3 R6 register content", rf[r], exp_rf[r]);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int r = 0; r < 8; r++) rf[r] = {$urandom, $urandom, $urandom};
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !mem_req && !rf_we && !done, "R1 reset outputs",
            {busy, mem_req, rf_we, done}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !mem_req && !rf_we && !done, "R1 after release",
            {busy, mem_req, rf_we, done}, 4'b0000);
        // directed corner cases
        run_op(1'b1, 2'd2, 8'hFF, 2'd0, 32'h0, 2'd1, 32'h200, 1'b0); // R4 all, ascending
        run_op(1'b1, 2'd0, 8'hFF, 2'd0, 32'h0, 2'd2, 32'h300, 1'b0); // R5 all, descending
        run_op(1'b0, 2'd1, 8'h00, 2'd2, 32'h0001_0000, 2'd2, 32'h280, 1'b0); // R2 R3 dyn bit0 -> reg0
        run_op(1'b0, 2'd2, 8'h80, 2'd0, 32'h0, 2'd1, 32'h240, 1'b0); // R3 bit7 -> reg0
        run_op(1'b0, 2'd3, 8'hFF, 2'd3, 32'h01FF_FFFF, 2'd1, 32'h220, 1'b0); // R2 dyn ascending
        run_op(1'b1, 2'd0, 8'h00, 2'd0, 32'hFFFF_FFFF, 2'd2, 32'h260, 1'b0); // R8 empty static
        run_op(1'b0, 2'd3, 8'hFF, 2'd1, 32'hFFFF_00FF, 2'd1, 32'h2A0, 1'b0); // R8 empty dynamic
        run_op(1'b1, 2'd2, 8'h5A, 2'd0, 32'h0, 2'd0, 32'h210, 1'b0); // R9 control, no wb
        run_op(1'b1, 2'd2, 8'hFF, 2'd0, 32'h0, 2'd1, 32'h200, 1'b1); // R10 start while busy
        // random mix
        for (int i = 0; i < 80; i++) begin
            run_op(1'($urandom), 2'($urandom), 8'($urandom), 2'($urandom), $urandom,
                   2'($urandom), 32'h200 + 4 * ($urandom % 64), 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule